// File: doc/BRIEF.md
# Mains Zero-Crossing Deglitcher

This block cleans up the digitized output of a mains comparator watching one phase of a 50 Hz or 60 Hz supply. The comparator bit is asynchronous to the system clock. The block first passes it through a two-flop synchronizer. It then applies a deliberately lopsided filter. A transition to high is accepted on the first synchronized sample that reads high. A transition to low is accepted only after the synchronized input has stayed low for a programmable number of consecutive clock cycles. Noise near a zero crossing can chatter the comparator, and this filter keeps such noise from producing a false falling crossing.

The cleaned level is the timing reference that a downstream frame-synchronization loop locks to. That loop also receives two one-cycle strobes, one when the cleaned level rises and one when it falls. With a 24 MHz clock, a window of 12000 to 24000 cycles covers 0.5 ms to 1 ms. A register outside the block supplies the window, and 18000 cycles (0.75 ms) is the recommended setting. All pins are plain level and strobe signals. There is no stream interface, so there is no valid/ready handshake and no back-pressure: the strobes are single pulses that the consumer must take in the cycle they occur.

Top module: `mains_zc_deglitch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the filtered level and both strobes are low. Any partial low-count is cleared by reset.
- R2: The comparator bit passes through two synchronizer flops. A change of the raw input that is set up before clock edge k is first seen by the filter at edge k+1, so a rising input makes the filtered level high after edge k+2.
- R3: Rising transitions are not filtered. A raw high lasting a single clock cycle, while the filtered level is low, makes the filtered level go high.
- R4: With an effective window of N cycles, the filtered level goes low only after the synchronized input has read low for N consecutive cycles. For a raw fall before edge k, the level is low after edge k+N+1 and still high after edge k+N.
- R5: If the synchronized input reads high before the low count completes, the count restarts from zero, the level stays high and no falling strobe occurs. Separate short lows do not add up.
- R6: The effective window is the programmed value clamped to the range QUAL_MIN..QUAL_MAX (defaults 12000 and 24000). Values below the range act as QUAL_MIN and values above it act as QUAL_MAX.
- R7: The rising strobe is high for exactly one cycle, in the first cycle that the filtered level reads high.
- R8: The falling strobe is high for exactly one cycle, in the first cycle that the filtered level reads low.
- R9: An input that agrees with the current filtered level has no effect. It causes no strobe and no level change, however long it lasts.
- R10: The two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cmp_raw_i | input | 1 | Raw comparator bit, asynchronous |
| qual_win_i | input | QUAL_W | Requested low-qualification window, in clock cycles |
| zc_level_o | output | 1 | Filtered mains level |
| zc_rise_o | output | 1 | One-cycle strobe on an accepted rising crossing |
| zc_fall_o | output | 1 | One-cycle strobe on an accepted falling crossing |

## Verification
The hardest case to reach is a low that ends exactly at the window boundary. The bench must show that N−1 low cycles are rejected and that N are accepted, and it must do this for an effective window that the clamp has changed, not for the value that was programmed. The bench drives the raw input on falling clock edges, so every raw low lasts a whole number of synchronized samples. The vector table pairs each programmed window with a low length one below the limit, at the limit and one above it, including requests under the minimum and over the maximum. A directed sequence of two short lows separated by a single high cycle checks that partial counts never add up.

// File: rtl/zc_pkg.sv
package zc_pkg;

  typedef enum logic {
    ZC_LOW  = 1'b0,
    ZC_HIGH = 1'b1
  } zc_level_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } zc_strobe_t;

endpackage

// File: rtl/zc_sync.sv
module zc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/zc_window_clamp.sv
module zc_window_clamp #(
  parameter int QUAL_W   = 15,
  parameter int QUAL_MIN = 12000,
  parameter int QUAL_MAX = 24000
) (
  input  logic [QUAL_W-1:0] req_i,
  output logic [QUAL_W-1:0] win_o
);

  localparam logic [QUAL_W-1:0] LoLim = QUAL_W'(QUAL_MIN);
  localparam logic [QUAL_W-1:0] HiLim = QUAL_W'(QUAL_MAX);

  always_comb begin
    if (req_i < LoLim)      win_o = LoLim;
    else if (req_i > HiLim) win_o = HiLim;
    else                    win_o = req_i;
  end

endmodule

// File: rtl/zc_fall_qualifier.sv
module zc_fall_qualifier
  import zc_pkg::*;
#(
  parameter int QUAL_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [QUAL_W-1:0] win_i,
  output zc_level_e         level_o,
  output zc_strobe_t        strb_o,
  output logic [QUAL_W-1:0] cnt_o
);

  zc_level_e         lvl_q;
  zc_strobe_t        strb_q;
  logic [QUAL_W-1:0] cnt_q;
  logic              expire;

  // Window may be lowered mid-count, so compare with >=.
  assign expire = (cnt_q >= (win_i - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= ZC_LOW;
      strb_q <= '0;
      cnt_q  <= '0;
    end else begin
      strb_q <= '0;
      unique case (lvl_q)
        ZC_LOW: begin
          cnt_q <= '0;
          if (sync_i) begin
            lvl_q       <= ZC_HIGH;
            strb_q.rise <= 1'b1;
          end
        end
        ZC_HIGH: begin
          if (sync_i) begin
            cnt_q <= '0;
          end else if (expire) begin
            cnt_q       <= '0;
            lvl_q       <= ZC_LOW;
            strb_q.fall <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: lvl_q <= ZC_LOW;
      endcase
    end
  end

  assign level_o = lvl_q;
  assign strb_o  = strb_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/mains_zc_deglitch.sv
module mains_zc_deglitch
  import zc_pkg::*;
#(
  parameter int QUAL_W      = 15,
  parameter int QUAL_MIN    = 12000,
  parameter int QUAL_MAX    = 24000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw_i,
  input  logic [QUAL_W-1:0] qual_win_i,
  output logic              zc_level_o,
  output logic              zc_rise_o,
  output logic              zc_fall_o
);

  logic              sync_lvl;
  logic [QUAL_W-1:0] eff_win;
  logic [QUAL_W-1:0] qual_cnt;
  zc_level_e         lvl;
  zc_strobe_t        strb;

  zc_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (cmp_raw_i),
    .q_o  (sync_lvl)
  );

  zc_window_clamp #(
    .QUAL_W  (QUAL_W),
    .QUAL_MIN(QUAL_MIN),
    .QUAL_MAX(QUAL_MAX)
  ) u_clamp (
    .req_i(qual_win_i),
    .win_o(eff_win)
  );

  zc_fall_qualifier #(
    .QUAL_W(QUAL_W)
  ) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_lvl),
    .win_i  (eff_win),
    .level_o(lvl),
    .strb_o (strb),
    .cnt_o  (qual_cnt)
  );

  assign zc_level_o = (lvl == ZC_HIGH);
  assign zc_rise_o  = strb.rise;
  assign zc_fall_o  = strb.fall;

endmodule

// File: rtl/zc_deglitch_checker.sv
module zc_deglitch_checker #(
  parameter int QUAL_W   = 15,
  parameter int QUAL_MAX = 24000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_lvl,
  input logic [QUAL_W-1:0] qual_cnt,
  input logic              level,
  input logic              rise,
  input logic              fall
);

  p_rise_marks_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (level && !$past(level)));

  p_fall_marks_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!level && $past(level)));

  p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));

  p_rise_unfiltered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && sync_lvl) |=> level);

  p_high_input_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level && sync_lvl) |=> (level && !fall));

  p_low_input_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && !sync_lvl) |=> (!level && !rise));

  p_count_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    qual_cnt < QUAL_W'(QUAL_MAX));

endmodule

bind mains_zc_deglitch zc_deglitch_checker #(
  .QUAL_W  (QUAL_W),
  .QUAL_MAX(QUAL_MAX)
) u_zc_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sync_lvl(sync_lvl),
  .qual_cnt(qual_cnt),
  .level   (zc_level_o),
  .rise    (zc_rise_o),
  .fall    (zc_fall_o)
);

// File: tb/tb_mains_zc_deglitch.sv
`timescale 1ns/1ps
module tb_mains_zc_deglitch;

  localparam int QW   = 6;
  localparam int QMIN = 8;
  localparam int QMAX = 40;
  localparam int NV   = 10;

  // programmed window, raw low length, expected fall (and later rise)
  localparam int V_QUAL [NV] = '{10, 10, 10,  3,  3, 60, 60,  8, 40, 20};
  localparam int V_LEN  [NV] = '{ 9, 10, 11,  7,  8, 39, 40,  1, 25, 20};
  localparam int V_EXP  [NV] = '{ 0,  1,  1,  0,  1,  0,  1,  0,  0,  1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_raw = 1'b0;
  logic [QW-1:0] qual_win = QW'(10);
  logic          zc_level, zc_rise, zc_fall;

  int n_checks = 0;
  int n_errors = 0;
  int rise_cnt = 0;
  int fall_cnt = 0;
  int strobe_bad = 0;
  logic prev_level = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mains_zc_deglitch #(
    .QUAL_W  (QW),
    .QUAL_MIN(QMIN),
    .QUAL_MAX(QMAX)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_raw_i (cmp_raw),
    .qual_win_i(qual_win),
    .zc_level_o(zc_level),
    .zc_rise_o (zc_rise),
    .zc_fall_o (zc_fall)
  );

  // Strobe monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (zc_rise) rise_cnt++;
      if (zc_fall) fall_cnt++;
      if (zc_rise != (zc_level && !prev_level)) strobe_bad++;
      if (zc_fall != (!zc_level && prev_level)) strobe_bad++;
      if (zc_rise && zc_fall) strobe_bad++;
    end
    prev_level = zc_level;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int r0, f0;
    // R1: reset state with raw input high
    cmp_raw = 1'b1;
    step(4);
    check("R1 level in reset", zc_level, 0);
    check("R1 strobes in reset", zc_rise | zc_fall, 0);
    cmp_raw = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 level after release", zc_level, 0);

    // R2/R3/R7: one-cycle raw high, latency of exactly three edges
    cmp_raw = 1'b1;
    step(1);
    cmp_raw = 1'b0;
    step(1);
    check("R2 level before third edge", zc_level, 0);
    step(1);
    check("R2 R3 level after third edge", zc_level, 1);
    check("R7 rise strobe with level", zc_rise, 1);
    step(1);
    check("R7 rise strobe one cycle", zc_rise, 0);
    cmp_raw = 1'b1;
    step(4);

    // Vector table walk: R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      qual_win = QW'(V_QUAL[v]);
      cmp_raw  = 1'b1;
      step(6);
      r0 = rise_cnt;
      f0 = fall_cnt;
      cmp_raw = 1'b0;
      step(V_LEN[v]);
      cmp_raw = 1'b1;
      step(6);
      check($sformatf("R4 R6 vec%0d fall count", v), fall_cnt - f0, V_EXP[v]);
      check($sformatf("R5 vec%0d rise count", v), rise_cnt - r0, V_EXP[v]);
      check($sformatf("R4 vec%0d level high again", v), zc_level, 1);
    end

    // R4: exact falling latency with N = 12
    qual_win = QW'(12);
    cmp_raw  = 1'b1;
    step(6);
    cmp_raw = 1'b0;
    step(13);
    check("R4 level still high at edge N", zc_level, 1);
    step(1);
    check("R4 level low after edge N+1", zc_level, 0);
    check("R8 fall strobe with level", zc_fall, 1);
    step(1);
    check("R8 fall strobe one cycle", zc_fall, 0);

    // R9: long low while already low
    r0 = rise_cnt;
    f0 = fall_cnt;
    step(60);
    check("R9 no strobe on held low", (rise_cnt - r0) + (fall_cnt - f0), 0);
    check("R9 level stays low", zc_level, 0);

    // R9: long high while already high
    cmp_raw = 1'b1;
    step(4);
    r0 = rise_cnt;
    step(60);
    check("R9 no strobe on held high", rise_cnt - r0, 0);

    // R5: two short lows split by one high cycle must not add up
    qual_win = QW'(10);
    f0 = fall_cnt;
    cmp_raw = 1'b0;
    step(9);
    cmp_raw = 1'b1;
    step(1);
    cmp_raw = 1'b0;
    step(9);
    cmp_raw = 1'b1;
    step(6);
    check("R5 short lows do not accumulate", fall_cnt - f0, 0);
    check("R5 level held high", zc_level, 1);

    // R1: reset mid-count clears partial count
    cmp_raw = 1'b0;
    step(7);
    rst_n = 1'b0;
    step(2);
    check("R1 level forced low", zc_level, 0);
    cmp_raw = 1'b1;
    rst_n = 1'b1;
    step(6);
    f0 = fall_cnt;
    cmp_raw = 1'b0;
    step(9);
    cmp_raw = 1'b1;
    step(6);
    check("R1 count cleared by reset", fall_cnt - f0, 0);

    // R7 R8 R10: strobe shape across the whole run
    check("R7 R8 R10 strobe shape", strobe_bad, 0);

    finish_run();
  end

endmodule